// File: doc/BRIEF.md
# Memory ECC Error Status Logger

This block turns error events from a memory controller's ECC checker and scrubber into software-visible status. Each event is sorted into one of four classes: a corrected single-bit error, an uncorrectable error on an ordinary demand read, an uncorrectable error found by the scrubber, and an error-threshold crossing reported by an external counter. The block records the class in one of two status registers and drives a level interrupt while any unmasked status bit is set. The first register captures the error that arrives when it is empty. The second register collects every error that arrives while the first one still holds something. A mask register suppresses both logging and interrupt for each class. All four classes are non-fatal.

Software reads and clears status through a small register port. It clears a bit by writing 1 to it. The status and mask registers survive the chip's warm reset and are cleared only by the cold, power-on reset. While warm reset is held, the block takes no events and no writes.

Top module: `mem_err_logger`

## Requirements
- R1: A cold reset (`cold_rst` high at a clock edge) clears the first-error, next-error and mask registers to zero, and `err_irq` is low afterwards.
- R2: The register addresses are 0 for first-error, 1 for next-error and 2 for mask. Address 3 reads as zero. Reads are combinational. In the status and mask registers, bit 0 is the corrected error, bit 1 the uncorrectable demand-read error, bit 2 the uncorrectable scrub error and bit 3 the threshold error. Bits above bit 3 read as 0, and writing them has no effect.
- R3: A `ecc_sec` pulse sets the corrected-error class (bit 0), whatever the state of `ecc_scrub`.
- R4: A `ecc_ded` pulse sets bit 1 when `ecc_scrub` is low and bit 2 when `ecc_scrub` is high, never both.
- R5: The threshold class (bit 3) is raised by `ecc_sec` while `sec_over_thr` is high, by `ecc_ded` while `ded_over_thr` is high, or by a `diag_sec_clr` strobe. An over-threshold flag with no event raises nothing.
- R6: Classes raised at a clock edge are logged into the first-error register if that register is zero before the edge. Otherwise they are logged into the next-error register. Several classes raised in the same cycle therefore land together in the same register. A logged bit is visible in the cycle after the edge.
- R7: A write of 1 to a status bit clears it, and a write of 0 leaves it unchanged. If a class is raised in the same cycle that its bit is written with 1, the bit ends up set.
- R8: While a mask bit is 1, its class is not logged in either status register.
- R9: A write that changes mask bit 3 from 1 to 0 while `sec_over_thr` or `ded_over_thr` is high logs the threshold class at that same edge, with no new event needed. A mask write that sets bit 3 or leaves it unchanged logs nothing.
- R10: `err_irq` is the OR of all status bits in both registers whose mask bit is 0. Masking a logged bit drops its contribution, and unmasking it restores it.
- R11: While `warm_rst` is high, the status and mask registers keep their values, and events, strobes and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high power-on reset; clears all state |
| warm_rst | input | 1 | Synchronous active-high warm reset; freezes state, blocks inputs |
| ecc_sec | input | 1 | Single-bit corrected error event pulse |
| ecc_ded | input | 1 | Uncorrectable error event pulse |
| ecc_scrub | input | 1 | Qualifier: the current event comes from a scrub read |
| sec_over_thr | input | 1 | Single-bit error counter is over its threshold |
| ded_over_thr | input | 1 | Uncorrectable error counter is over its threshold |
| diag_sec_clr | input | 1 | Strobe: software cleared the single-bit error count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| err_irq | output | 1 | Level interrupt, high while any unmasked status bit is set |

## Verification
Two functions can collide in one cycle: a hardware event and a software write-1 clear of the same status bit, and an unmask write to bit 3 while a counter is over threshold. The bench pairs a clear of the next-error register with a new corrected error, and expects the bit to end up set. It also clears the threshold mask while holding an over-threshold flag with no event, and expects bit 3 to read back in the next cycle. Simultaneous corrected and uncorrectable events are also applied, and both must land together in the first-error register.

// File: rtl/mel_pkg.sv
package mel_pkg;

    localparam int NUM_CLS    = 4;
    localparam int CLS_CE     = 0;
    localparam int CLS_DUE    = 1;
    localparam int CLS_SUE    = 2;
    localparam int CLS_THR    = 3;
    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_FIRST = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_NEXT  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK  = 2'd2;

    typedef logic [NUM_CLS-1:0] cls_vec_t;

    typedef struct packed {
        logic sec;
        logic ded;
        logic scrub;
    } ecc_evt_t;

    typedef struct packed {
        logic sec_over;
        logic ded_over;
    } cnt_flag_t;

    typedef enum logic [1:0] {
        SEL_FIRST,
        SEL_NEXT,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [REG_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_FIRST: s = SEL_FIRST;
            ADDR_NEXT:  s = SEL_NEXT;
            ADDR_MASK:  s = SEL_MASK;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Sort one cycle of raw inputs into the four error classes.
    function automatic cls_vec_t classify_evt(ecc_evt_t e, cnt_flag_t f, logic diag);
        cls_vec_t v;
        v          = '0;
        v[CLS_CE]  = e.sec;
        v[CLS_DUE] = e.ded && !e.scrub;
        v[CLS_SUE] = e.ded && e.scrub;
        v[CLS_THR] = (e.sec && f.sec_over) || (e.ded && f.ded_over) || diag;
        return v;
    endfunction

endpackage

// File: rtl/mel_ctrl_regs.sv
module mel_ctrl_regs
    import mel_pkg::*;
(
    input  logic                  clk,
    input  logic                  cold_rst,
    input  logic                  warm_rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  cls_vec_t              wr_bits,
    input  cnt_flag_t             flags,
    output cls_vec_t              mask_q,
    output cls_vec_t              clr_first,
    output cls_vec_t              clr_next,
    output logic                  unmask_thr
);

    reg_sel_e sel;
    logic     wr_ok;
    logic     mask_wr;

    assign sel     = decode_addr(reg_addr);
    assign wr_ok   = reg_wr && !warm_rst;
    assign mask_wr = wr_ok && (sel == SEL_MASK);

    assign clr_first = (wr_ok && sel == SEL_FIRST) ? wr_bits : '0;
    assign clr_next  = (wr_ok && sel == SEL_NEXT)  ? wr_bits : '0;

    // Releasing the threshold mask while a counter is already high reports at once.
    assign unmask_thr = mask_wr && mask_q[CLS_THR] && !wr_bits[CLS_THR]
                        && (flags.sec_over || flags.ded_over);

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= wr_bits;
        end
    end

    AST_MASK_WARM_HOLD: assert property (@(posedge clk) disable iff (cold_rst)
        (warm_rst && reg_wr) |=> $stable(mask_q)); // R11

    AST_MASK_COLD_CLEAR: assert property (@(posedge clk)
        cold_rst |=> (mask_q == '0)); // R1

endmodule

// File: rtl/mel_classify.sv
module mel_classify
    import mel_pkg::*;
(
    input  logic      warm_rst,
    input  ecc_evt_t  evt,
    input  cnt_flag_t flags,
    input  logic      diag_clr,
    input  cls_vec_t  mask_q,
    input  logic      unmask_thr,
    output cls_vec_t  evt_vec
);

    cls_vec_t raw;
    cls_vec_t late_thr;

    assign raw = warm_rst ? '0 : classify_evt(evt, flags, diag_clr);

    generate
        for (genvar i = 0; i < NUM_CLS; i++) begin : g_late
            if (i == CLS_THR) begin : g_thr
                assign late_thr[i] = unmask_thr;
            end else begin : g_other
                assign late_thr[i] = 1'b0;
            end
        end
    endgenerate

    assign evt_vec = (raw & ~mask_q) | late_thr;

endmodule

// File: rtl/mel_status_bank.sv
module mel_status_bank
    import mel_pkg::*;
(
    input  logic     clk,
    input  logic     cold_rst,
    input  logic     warm_rst,
    input  cls_vec_t evt_vec,
    input  cls_vec_t clr_first,
    input  cls_vec_t clr_next,
    output cls_vec_t first_q,
    output cls_vec_t next_q
);

    logic     first_empty;
    cls_vec_t first_d;
    cls_vec_t next_d;

    assign first_empty = (first_q == '0);

    generate
        for (genvar i = 0; i < NUM_CLS; i++) begin : g_bit
            // Set is ORed after the clear so a same-cycle event survives.
            assign first_d[i] = (first_q[i] && !clr_first[i]) || (first_empty && evt_vec[i]);
            assign next_d[i]  = (next_q[i]  && !clr_next[i])  || (!first_empty && evt_vec[i]);

            AST_SET_WINS: assert property (@(posedge clk) disable iff (cold_rst)
                evt_vec[i] |=> (first_q[i] || next_q[i])); // R7

            AST_W1C_ONLY: assert property (@(posedge clk) disable iff (cold_rst)
                (first_q[i] && !clr_first[i]) |=> first_q[i]); // R7
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            first_q <= '0;
            next_q  <= '0;
        end else begin
            first_q <= first_d;
            next_q  <= next_d;
        end
    end

    AST_FIRST_ROUTE: assert property (@(posedge clk) disable iff (cold_rst)
        (first_empty && evt_vec != '0) |=> (first_q == $past(evt_vec))); // R6

    AST_NEXT_ROUTE: assert property (@(posedge clk) disable iff (cold_rst)
        (!first_empty && evt_vec != '0) |=> ((next_q & $past(evt_vec)) == $past(evt_vec))); // R6

    AST_STATUS_WARM_HOLD: assert property (@(posedge clk) disable iff (cold_rst)
        warm_rst |=> ($stable(first_q) && $stable(next_q))); // R11

    AST_STATUS_COLD_CLEAR: assert property (@(posedge clk)
        cold_rst |=> (first_q == '0 && next_q == '0)); // R1

endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
    import mel_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              ecc_sec,
    input  logic              ecc_ded,
    input  logic              ecc_scrub,
    input  logic              sec_over_thr,
    input  logic              ded_over_thr,
    input  logic              diag_sec_clr,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              err_irq
);

    localparam int PAD_W = DATA_W - NUM_CLS;

    ecc_evt_t  evt;
    cnt_flag_t flags;
    cls_vec_t  wr_bits;
    cls_vec_t  mask_q;
    cls_vec_t  clr_first;
    cls_vec_t  clr_next;
    cls_vec_t  evt_vec;
    cls_vec_t  first_q;
    cls_vec_t  next_q;
    logic      unmask_thr;
    logic      wdata_unused;

    assign evt          = '{sec: ecc_sec, ded: ecc_ded, scrub: ecc_scrub};
    assign flags        = '{sec_over: sec_over_thr, ded_over: ded_over_thr};
    assign wr_bits      = reg_wdata[NUM_CLS-1:0];
    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_CLS];

    mel_ctrl_regs i_ctrl (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .warm_rst   (warm_rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .wr_bits    (wr_bits),
        .flags      (flags),
        .mask_q     (mask_q),
        .clr_first  (clr_first),
        .clr_next   (clr_next),
        .unmask_thr (unmask_thr)
    );

    mel_classify i_classify (
        .warm_rst   (warm_rst),
        .evt        (evt),
        .flags      (flags),
        .diag_clr   (diag_sec_clr),
        .mask_q     (mask_q),
        .unmask_thr (unmask_thr),
        .evt_vec    (evt_vec)
    );

    mel_status_bank i_bank (
        .clk       (clk),
        .cold_rst  (cold_rst),
        .warm_rst  (warm_rst),
        .evt_vec   (evt_vec),
        .clr_first (clr_first),
        .clr_next  (clr_next),
        .first_q   (first_q),
        .next_q    (next_q)
    );

    assign err_irq = |((first_q | next_q) & ~mask_q);

    always_comb begin
        case (decode_addr(reg_addr))
            SEL_FIRST: reg_rdata = {{PAD_W{1'b0}}, first_q};
            SEL_NEXT:  reg_rdata = {{PAD_W{1'b0}}, next_q};
            SEL_MASK:  reg_rdata = {{PAD_W{1'b0}}, mask_q};
            default:   reg_rdata = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < NUM_CLS; i++) begin : g_mask_chk
            AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (cold_rst)
                (mask_q[i] && !first_q[i] && !next_q[i]
                 && !(reg_wr && reg_addr == ADDR_MASK)) |=> (!first_q[i] && !next_q[i])); // R8
        end
    endgenerate

    AST_UNMASK_THR: assert property (@(posedge clk) disable iff (cold_rst)
        (reg_wr && !warm_rst && reg_addr == ADDR_MASK && mask_q[CLS_THR]
         && !reg_wdata[CLS_THR] && (sec_over_thr || ded_over_thr))
        |=> (first_q[CLS_THR] || next_q[CLS_THR])); // R9

    AST_IRQ_FOLLOWS_LOG: assert property (@(posedge clk) disable iff (cold_rst)
        ((evt_vec != '0) && !(reg_wr && reg_addr == ADDR_MASK)) |=> err_irq); // R10

endmodule

// File: tb/test_mem_err_logger.sv
module test_mem_err_logger;

    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        ecc_sec = 1'b0;
    logic        ecc_ded = 1'b0;
    logic        ecc_scrub = 1'b0;
    logic        sec_over_thr = 1'b0;
    logic        ded_over_thr = 1'b0;
    logic        diag_sec_clr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mem_err_logger #(.DATA_W(16)) i_mem_err_logger (
        .clk          (clk),
        .cold_rst     (cold_rst),
        .warm_rst     (warm_rst),
        .ecc_sec      (ecc_sec),
        .ecc_ded      (ecc_ded),
        .ecc_scrub    (ecc_scrub),
        .sec_over_thr (sec_over_thr),
        .ded_over_thr (ded_over_thr),
        .diag_sec_clr (diag_sec_clr),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .err_irq      (err_irq)
    );

    // Fields: [21] wr, [20:19] addr, [18:15] wdata, [14:9] sec,ded,scrub,sovr,dovr,diag,
    //         [8:5] expected first, [4:1] expected next, [0] expected irq
    localparam int NVEC = 20;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 4'h0, 6'b000000, 4'h0, 4'h0, 1'b0},  // R1 idle
        {1'b0, 2'd0, 4'h0, 6'b100000, 4'h1, 4'h0, 1'b1},  // R3 R6 demand CE to first
        {1'b0, 2'd0, 4'h0, 6'b010000, 4'h1, 4'h2, 1'b1},  // R4 R6 demand UE to next
        {1'b0, 2'd0, 4'h0, 6'b011000, 4'h1, 4'h6, 1'b1},  // R4 scrub UE
        {1'b0, 2'd0, 4'h0, 6'b101000, 4'h1, 4'h7, 1'b1},  // R3 scrub CE
        {1'b0, 2'd0, 4'h0, 6'b100100, 4'h1, 4'hF, 1'b1},  // R5 CE over threshold
        {1'b0, 2'd0, 4'h0, 6'b000100, 4'h1, 4'hF, 1'b1},  // R5 flag alone
        {1'b1, 2'd1, 4'h3, 6'b000000, 4'h1, 4'hC, 1'b1},  // R7 partial clear
        {1'b1, 2'd0, 4'h1, 6'b000000, 4'h0, 4'hC, 1'b1},  // R7
        {1'b0, 2'd0, 4'h0, 6'b010010, 4'hA, 4'hC, 1'b1},  // R5 R6 empty first refills
        {1'b1, 2'd0, 4'h0, 6'b000000, 4'hA, 4'hC, 1'b1},  // R7 write zero
        {1'b1, 2'd1, 4'hF, 6'b100000, 4'hA, 4'h1, 1'b1},  // R7 set beats clear
        {1'b1, 2'd0, 4'hF, 6'b000000, 4'h0, 4'h1, 1'b1},  // R7
        {1'b1, 2'd1, 4'hF, 6'b000000, 4'h0, 4'h0, 1'b0},  // R10 all clear
        {1'b0, 2'd0, 4'h0, 6'b000001, 4'h8, 4'h0, 1'b1},  // R5 diag strobe
        {1'b1, 2'd0, 4'hF, 6'b000000, 4'h0, 4'h0, 1'b0},  // R7
        {1'b0, 2'd0, 4'h0, 6'b110000, 4'h3, 4'h0, 1'b1},  // R6 simultaneous
        {1'b1, 2'd0, 4'hF, 6'b000000, 4'h0, 4'h0, 1'b0},  // R7
        {1'b0, 2'd0, 4'h0, 6'b011010, 4'hC, 4'h0, 1'b1},  // R4 R5 scrub UE over threshold
        {1'b1, 2'd0, 4'hF, 6'b000000, 4'h0, 4'h0, 1'b0}   // R7
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply(input logic wr, input logic [1:0] addr, input logic [15:0] wd,
                         input logic [5:0] ev, input logic warm);
        @(negedge clk);
        reg_wr       = wr;
        reg_addr     = addr;
        reg_wdata    = wd;
        ecc_sec      = ev[5];
        ecc_ded      = ev[4];
        ecc_scrub    = ev[3];
        sec_over_thr = ev[2];
        ded_over_thr = ev[1];
        diag_sec_clr = ev[0];
        warm_rst     = warm;
        @(posedge clk);
        #1;
        reg_wr       = 1'b0;
        ecc_sec      = 1'b0;
        ecc_ded      = 1'b0;
        ecc_scrub    = 1'b0;
        sec_over_thr = 1'b0;
        ded_over_thr = 1'b0;
        diag_sec_clr = 1'b0;
        warm_rst     = 1'b0;
    endtask

    task automatic rd(input logic [1:0] addr, output logic [15:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic expect_regs(input string req, input logic [15:0] ef,
                               input logic [15:0] en, input logic ei);
        logic [15:0] v;
        rd(2'd0, v);
        chk({req, " first"}, v, ef);
        rd(2'd1, v);
        chk({req, " next"}, v, en);
        chk({req, " irq"}, {15'b0, err_irq}, {15'b0, ei});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1;
        cold_rst = 1'b0;

        // R1 R2 reset state
        expect_regs("R1", 16'h0, 16'h0, 1'b0);
        rd(2'd2, v);
        chk("R1 mask", v, 16'h0);
        rd(2'd3, v);
        chk("R2 unused addr", v, 16'h0);

        // Vector walk
        for (int n = 0; n < NVEC; n++) begin
            apply(VEC[n][21], VEC[n][20:19], {12'h0, VEC[n][18:15]}, VEC[n][14:9], 1'b0);
            expect_regs($sformatf("vec%0d", n), {12'h0, VEC[n][8:5]}, {12'h0, VEC[n][4:1]}, VEC[n][0]);
        end

        // R8 masking
        apply(1'b1, 2'd2, 16'h0001, 6'b000000, 1'b0);
        rd(2'd2, v);
        chk("R2 mask readback", v, 16'h0001);
        apply(1'b0, 2'd0, 16'h0, 6'b100000, 1'b0);
        expect_regs("R8 CE masked", 16'h0, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'h0002, 6'b000000, 1'b0);
        apply(1'b0, 2'd0, 16'h0, 6'b010000, 1'b0);
        expect_regs("R8 DUE masked", 16'h0, 16'h0, 1'b0);
        apply(1'b0, 2'd0, 16'h0, 6'b011000, 1'b0);
        expect_regs("R8 R4 SUE unmasked", 16'h4, 16'h0, 1'b1);

        // R10 irq follows mask of a logged bit
        apply(1'b1, 2'd2, 16'h0004, 6'b000000, 1'b0);
        expect_regs("R10 masked after log", 16'h4, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'h0000, 6'b000000, 1'b0);
        expect_regs("R10 unmasked again", 16'h4, 16'h0, 1'b1);
        apply(1'b1, 2'd0, 16'h000F, 6'b000000, 1'b0);

        // R9 late reporting on threshold unmask
        apply(1'b1, 2'd2, 16'h0008, 6'b000000, 1'b0);
        apply(1'b0, 2'd0, 16'h0, 6'b100100, 1'b0);
        expect_regs("R9 thr masked", 16'h1, 16'h0, 1'b1);
        apply(1'b1, 2'd0, 16'h000F, 6'b000100, 1'b0);
        expect_regs("R9 cleared", 16'h0, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'h0000, 6'b000100, 1'b0);
        expect_regs("R9 unmask while over", 16'h8, 16'h0, 1'b1);
        apply(1'b1, 2'd0, 16'h000F, 6'b000000, 1'b0);
        apply(1'b1, 2'd2, 16'h0008, 6'b000000, 1'b0);
        apply(1'b1, 2'd2, 16'h0000, 6'b000000, 1'b0);
        expect_regs("R9 unmask no flag", 16'h0, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'h0000, 6'b000010, 1'b0);
        expect_regs("R9 no change", 16'h0, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'h0008, 6'b000010, 1'b0);
        expect_regs("R9 mask set", 16'h0, 16'h0, 1'b0);
        apply(1'b1, 2'd2, 16'hFFF0, 6'b000000, 1'b0);
        rd(2'd2, v);
        chk("R2 upper write bits", v, 16'h0000);

        // R11 warm reset keeps state and blocks inputs
        apply(1'b0, 2'd0, 16'h0, 6'b100000, 1'b0);
        apply(1'b1, 2'd2, 16'h0002, 6'b000000, 1'b0);
        apply(1'b1, 2'd0, 16'h000F, 6'b011000, 1'b1);
        expect_regs("R11 warm event+clear", 16'h1, 16'h0, 1'b1);
        apply(1'b1, 2'd2, 16'h0000, 6'b000001, 1'b1);
        rd(2'd2, v);
        chk("R11 warm mask write", v, 16'h0002);
        expect_regs("R11 warm diag", 16'h1, 16'h0, 1'b1);
        apply(1'b0, 2'd0, 16'h0, 6'b000000, 1'b0);
        expect_regs("R11 after warm", 16'h1, 16'h0, 1'b1);

        // R1 cold reset clears everything
        @(negedge clk);
        cold_rst = 1'b1;
        @(posedge clk);
        #1;
        cold_rst = 1'b0;
        expect_regs("R1 cold", 16'h0, 16'h0, 1'b0);
        rd(2'd2, v);
        chk("R1 cold mask", v, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule